// File: doc/BRIEF.md
# Receive Buffer Descriptor Writer

This block takes one received Ethernet frame at a time, presented as a byte stream with start, end and error markers, and stores it in a ring of fixed-size receive buffers in system memory. Each ring entry has a two-word descriptor. Before filling an entry's buffer, the block reads the descriptor's address word. If software still owns that entry, the block drops the frame and pulses a resource-error status. Otherwise it streams the bytes into the buffer as little-endian words.

When the buffer is full, or the frame ends, the block writes the descriptor's control word. That word carries the first/last fragment flags and, in the last fragment only, the total frame length. The block then writes the address word back with its used bit set. A frame longer than one buffer continues in the following descriptors. The ring index returns to zero after an entry whose wrap bit is set, or after the last index. A one-cycle completion pulse follows the last descriptor of every complete frame.

The block uses one word-wide memory port, shared by the descriptor ring and the buffer area. This port accepts a read or a write in every cycle and returns read data on the next cycle. The byte stream is throttled through a ready output while the block talks to the descriptors.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset the block issues no memory read or write and holds `rx_done` and `rsrc_err` low.
- R2: A byte with `in_sof` set, seen while `en` is high, starts a frame. The block first reads the address word of the current descriptor at `ring_base + 8*index`. In that word, bit 0 is the used (software-owned) flag and bit 1 is the wrap flag.
- R3: Frame bytes are packed little-endian (first byte in bits 7:0) into 32-bit words. They are written at `buf_base + BUF_BYTES*index + offset`, and the unused bytes of a final partial word are written as zero.
- R4: A frame longer than `BUF_BYTES` continues in the next descriptor. A frame of exactly `BUF_BYTES` bytes uses a single descriptor.
- R5: The control word at descriptor address + 4 has bit 14 set on the first fragment and bit 15 set on the last fragment. Bits [LEN_W-1:0] hold the total frame length in the last fragment and are zero in the other fragments. All other bits are zero.
- R6: For each filled entry, the control word is written after the entry's data, and the address word is written last. The address word is written with bit 0 set and all its other bits unchanged.
- R7: `rx_done` pulses for exactly one cycle, once per complete frame, after the last address word has been written.
- R8: After an entry whose wrap bit is set, the next entry used is index 0.
- R9: If the address word read shows the used bit set, `rsrc_err` pulses for one cycle. The rest of the frame is consumed without any memory write, and the same descriptor is tried again by the next frame.
- R10: A byte with `in_err` set aborts the frame. The fragment in progress is not handed over, earlier fragments stay used with a start flag and no end flag, no `rx_done` is raised, and the next frame starts in the aborted fragment's descriptor.
- R11: Bytes are consumed with no memory access when they arrive while idle without `in_sof`, or when the frame starts while `en` is low.
- R12: `mem_rd` and `mem_wr` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receive enable, sampled at frame start |
| ring_base | input | AW | Byte address of descriptor 0 |
| buf_base | input | AW | Byte address of the buffer for entry 0 |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame aborted; this byte is discarded |
| in_ready | output | 1 | Block accepts the stream byte this cycle |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| rx_done | output | 1 | One-cycle frame-complete pulse |
| rsrc_err | output | 1 | One-cycle pulse: descriptor still owned by software |

## Verification
The bench builds the block with 16-byte buffers and an 8-entry ring. Only the first four entries are initialized, and the wrap flag is set on entry 3. With these values, multi-fragment frames, a frame that exactly fills one buffer, and a frame that crosses the wrap all come within a few dozen bytes. Because the index wraps on the flag and not on the ring size, the bench can tell the wrap bit apart from the natural end of the ring. Leaving entries owned by software between frames brings the resource-error path and the retry of the same descriptor within reach. The short ring also makes it cheap to check the abort path, and to check that the next frame reuses the descriptor of an abandoned fragment.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   localparam int USED_POS = 0;
   localparam int WRAP_POS = 1;
   localparam int SOF_POS  = 14;
   localparam int EOF_POS  = 15;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_CHK,
      ST_DATA,
      ST_WCTRL,
      ST_WADDR,
      ST_DROP
   } rxd_state_e;
endpackage

// File: rtl/rxd_byte_pack.sv
module rxd_byte_pack #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          take,
   input  logic          last,
   input  logic [7:0]    byte_in,
   output logic          emit,
   output logic [DW-1:0] word
);
   localparam int LANES = DW / 8;

   generate
      if (LANES == 1) begin : g_narrow
         assign emit = take;
         assign word = byte_in;
      end else begin : g_wide
         localparam int LB = $clog2(LANES);
         logic [LB-1:0]           lane_q;
         logic [LANES-1:0][7:0]   held_q;

         always_comb begin
            for (int j = 0; j < LANES; j++) begin
               if (j < int'(lane_q))       word[j*8 +: 8] = held_q[j];
               else if (j == int'(lane_q)) word[j*8 +: 8] = byte_in;
               else                        word[j*8 +: 8] = 8'h00;
            end
         end

         assign emit = take && (lane_q == LB'(LANES - 1) || last);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
               held_q <= '0;
            end else if (clr) begin
               lane_q <= '0;
            end else if (take) begin
               if (emit) begin
                  lane_q <= '0;
               end else begin
                  held_q[lane_q] <= byte_in;
                  lane_q         <= lane_q + 1'b1;
               end
            end
         end

         // R3
         pack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            emit |=> (lane_q == '0));
      end
   endgenerate
endmodule

// File: rtl/rxd_addr_gen.sv
module rxd_addr_gen #(
   parameter int AW    = 32,
   parameter int IDX_W = 9,
   parameter int OFF_W = 7,
   parameter int LB    = 2
) (
   input  logic [AW-1:0]    ring_base,
   input  logic [AW-1:0]    buf_base,
   input  logic [IDX_W-1:0] idx,
   input  logic [OFF_W-1:0] byte_off,
   output logic [AW-1:0]    desc_addr,
   output logic [AW-1:0]    ctrl_addr,
   output logic [AW-1:0]    data_addr
);
   logic [AW-1:0] idx_ext;
   logic [AW-1:0] off_ext;

   assign idx_ext   = AW'(idx);
   assign off_ext   = AW'({byte_off[OFF_W-1:LB], {LB{1'b0}}});
   assign desc_addr = ring_base + (idx_ext << 3);
   assign ctrl_addr = desc_addr + AW'(4);
   assign data_addr = buf_base + (idx_ext << OFF_W) + off_ext;
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
   import rxd_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int BUF_BYTES  = 128,
   parameter int RING_DEPTH = 512,
   parameter int LEN_W      = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] ring_base,
   input  logic [AW-1:0] buf_base,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_sof,
   input  logic          in_eof,
   input  logic          in_err,
   output logic          in_ready,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          rx_done,
   output logic          rsrc_err
);
   localparam int LANES = DW / 8;
   localparam int LB    = (LANES > 1) ? $clog2(LANES) : 0;
   localparam int IDX_W = $clog2(RING_DEPTH);
   localparam int OFF_W = $clog2(BUF_BYTES);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("rx_desc_writer: DW must be 32");
      end
      if ((1 << OFF_W) != BUF_BYTES || BUF_BYTES < LANES) begin : g_bad_buf
         $error("rx_desc_writer: BUF_BYTES must be a power of two of at least one word");
      end
      if (RING_DEPTH < 2) begin : g_bad_depth
         $error("rx_desc_writer: RING_DEPTH must be at least 2");
      end
      if (LEN_W > SOF_POS) begin : g_bad_len
         $error("rx_desc_writer: LEN_W overlaps the fragment flags");
      end
   endgenerate

   rxd_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [OFF_W-1:0] off_q;
   logic [LEN_W-1:0] len_q;
   logic [DW-1:0]    desc_q;
   logic             first_q;
   logic             last_q;
   logic             done_q;
   logic             err_q;

   logic             take;
   logic             emit;
   logic [DW-1:0]    pack_word;
   logic [AW-1:0]    desc_addr;
   logic [AW-1:0]    ctrl_addr;
   logic [AW-1:0]    data_addr;
   logic [IDX_W-1:0] idx_next;
   logic [DW-1:0]    ctrl_word;

   // stream acceptance
   always_comb begin
      unique case (state_q)
         ST_IDLE: in_ready = !(en && in_valid && in_sof);
         ST_DATA: in_ready = 1'b1;
         ST_DROP: in_ready = 1'b1;
         default: in_ready = 1'b0;
      endcase
   end
   assign take = in_valid && in_ready;

   rxd_byte_pack #(.DW(DW)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state_q == ST_CHK),
      .take    (take && (state_q == ST_DATA) && !in_err),
      .last    (in_eof),
      .byte_in (in_data),
      .emit    (emit),
      .word    (pack_word)
   );

   rxd_addr_gen #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W), .LB(LB)) u_addr (
      .ring_base (ring_base),
      .buf_base  (buf_base),
      .idx       (idx_q),
      .byte_off  (off_q),
      .desc_addr (desc_addr),
      .ctrl_addr (ctrl_addr),
      .data_addr (data_addr)
   );

   assign idx_next = (desc_q[WRAP_POS] || idx_q == IDX_W'(RING_DEPTH - 1))
                     ? '0 : idx_q + 1'b1;

   always_comb begin
      ctrl_word = '0;
      if (last_q) ctrl_word[LEN_W-1:0] = len_q;
      ctrl_word[SOF_POS] = first_q;
      ctrl_word[EOF_POS] = last_q;
   end

   // memory port
   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = desc_addr;
      mem_wdata = '0;
      unique case (state_q)
         ST_RD: mem_rd = 1'b1;
         ST_DATA: begin
            mem_wr    = emit;
            mem_addr  = data_addr;
            mem_wdata = pack_word;
         end
         ST_WCTRL: begin
            mem_wr    = 1'b1;
            mem_addr  = ctrl_addr;
            mem_wdata = ctrl_word;
         end
         ST_WADDR: begin
            mem_wr    = 1'b1;
            mem_wdata = desc_q | (DW'(1) << USED_POS);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         off_q   <= '0;
         len_q   <= '0;
         desc_q  <= '0;
         first_q <= 1'b0;
         last_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (en && in_valid && in_sof) begin
                  state_q <= ST_RD;
                  first_q <= 1'b1;
                  len_q   <= '0;
               end
            end
            ST_RD: state_q <= ST_CHK;
            ST_CHK: begin
               desc_q <= mem_rdata;
               off_q  <= '0;
               if (mem_rdata[USED_POS]) begin
                  err_q   <= 1'b1;
                  state_q <= ST_DROP;
               end else begin
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (take) begin
                  if (in_err) begin
                     state_q <= ST_IDLE;
                  end else begin
                     len_q <= len_q + 1'b1;
                     off_q <= off_q + 1'b1;
                     if (in_eof) begin
                        last_q  <= 1'b1;
                        state_q <= ST_WCTRL;
                     end else if (off_q == OFF_W'(BUF_BYTES - 1)) begin
                        last_q  <= 1'b0;
                        state_q <= ST_WCTRL;
                     end
                  end
               end
            end
            ST_WCTRL: state_q <= ST_WADDR;
            ST_WADDR: begin
               first_q <= 1'b0;
               idx_q   <= idx_next;
               if (last_q) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_RD;
               end
            end
            ST_DROP: begin
               if (take && (in_eof || in_err)) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rx_done  = done_q;
   assign rsrc_err = err_q;

   // R12
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R7
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(mem_wr));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R9
   err_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsrc_err |-> $past(mem_rd, 2));

   // R9
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_done && rsrc_err));

   // R2
   no_stream_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !in_ready);
endmodule

// File: tb/tb_rx_desc_writer.sv
module tb_rx_desc_writer;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int BUF_BYTES = 16;
   localparam int RING_DEPTH = 8;
   localparam int LEN_W = 12;
   localparam logic [31:0] RING_BASE = 32'h0000_0000;
   localparam logic [31:0] BUF_BASE  = 32'h0000_0100;
   localparam logic [31:0] UNTOUCHED = 32'hDEAD_BEEF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b1;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_sof = 1'b0;
   logic          in_eof = 1'b0;
   logic          in_err = 1'b0;
   logic          in_ready;
   logic          mem_rd;
   logic          mem_wr;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic          rx_done;
   logic          rsrc_err;

   int n_checks = 0;
   int n_errors = 0;
   int wr_count = 0;
   int done_count = 0;
   int err_count = 0;

   logic [31:0] mem [128];

   always #4 clk = ~clk;

   rx_desc_writer #(.AW(AW), .DW(DW), .BUF_BYTES(BUF_BYTES),
                    .RING_DEPTH(RING_DEPTH), .LEN_W(LEN_W)) dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .ring_base(RING_BASE), .buf_base(BUF_BASE),
      .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
      .in_eof(in_eof), .in_err(in_err), .in_ready(in_ready),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rx_done(rx_done), .rsrc_err(rsrc_err)
   );

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      if (mem_wr) begin
         mem[mem_addr[8:2]] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
      if (mem_rd) mem_rdata <= mem[mem_addr[8:2]];
   end

   always @(negedge clk) begin
      if (rx_done)  done_count++;
      if (rsrc_err) err_count++;
   end

   function automatic logic [31:0] tag(input int i);
      return 32'h0A00_0000 | (32'(i) << 8) | ((i == 3) ? 32'h2 : 32'h0);
   endfunction

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[8:2]];
   endfunction

   function automatic logic [31:0] exp_word(input logic [7:0] seed, input int k0, input int n);
      logic [31:0] w = '0;
      for (int j = 0; j < 4; j++)
         if (k0 + j < n) w[j*8 +: 8] = seed + 8'(k0 + j);
      return w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic give_back(input int i);
      mem[(RING_BASE + 32'(i) * 8) >> 2]     = tag(i);
      mem[(RING_BASE + 32'(i) * 8 + 4) >> 2] = UNTOUCHED;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input int n, input logic [7:0] seed, input bit with_sof, input bit with_err);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = seed + 8'(k);
         in_sof   = with_sof && (k == 0);
         in_eof   = (k == n - 1) && !with_err;
         in_err   = (k == n - 1) && with_err;
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof = 1'b0;
      in_eof = 1'b0;
      in_err = 1'b0;
      idle(12);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 mem_rd", 32'(mem_rd), 0);
      chk("R1 mem_wr", 32'(mem_wr), 0);
      chk("R1 rx_done", 32'(rx_done), 0);
      chk("R1 rsrc_err", 32'(rsrc_err), 0);
   endtask

   task automatic t_short;
      send(5, 8'h10, 1, 0);
      chk("R6 used set idx0", rd(32'h00), tag(0) | 1);
      chk("R5 ctrl idx0", rd(32'h04), 32'h0000_C005);
      chk("R3 word0", rd(BUF_BASE), exp_word(8'h10, 0, 5));
      chk("R3 partial word zero fill", rd(BUF_BASE + 4), exp_word(8'h10, 4, 5));
      chk("R7 done pulse", 32'(done_count), 1);
   endtask

   task automatic t_exact;
      send(16, 8'h30, 1, 0);
      chk("R4 exact ctrl idx1", rd(32'h0C), 32'h0000_C010);
      chk("R6 used idx1", rd(32'h08), tag(1) | 1);
      chk("R4 idx2 untouched", rd(32'h14), UNTOUCHED);
      chk("R3 last word idx1", rd(BUF_BASE + 16 + 12), exp_word(8'h30, 12, 16));
      chk("R7 done count", 32'(done_count), 2);
   endtask

   task automatic t_multi_wrap;
      give_back(0);
      send(40, 8'h40, 1, 0);
      chk("R5 first frag ctrl", rd(32'h14), 32'h0000_4000);
      chk("R5 middle frag ctrl", rd(32'h1C), 32'h0000_0000);
      chk("R8 wrap to idx0 ctrl", rd(32'h04), 32'h0000_8028);
      chk("R6 used keeps wrap idx3", rd(32'h18), tag(3) | 1);
      chk("R8 idx4 untouched", rd(32'h24), 32'h0);
      chk("R4 frag1 word0", rd(BUF_BASE + 32), exp_word(8'h40, 0, 40));
      chk("R4 frag3 word0", rd(BUF_BASE), exp_word(8'h40, 32, 40));
      chk("R4 frag3 word1", rd(BUF_BASE + 4), exp_word(8'h40, 36, 40));
      chk("R7 done count", 32'(done_count), 3);
   endtask

   task automatic t_rsrc;
      int w0 = wr_count;
      send(8, 8'h60, 1, 0);
      chk("R9 rsrc_err pulse", 32'(err_count), 1);
      chk("R9 no writes", 32'(wr_count - w0), 0);
      chk("R9 no done", 32'(done_count), 3);
      chk("R9 ctrl idx1 unchanged", rd(32'h0C), 32'h0000_C010);
      give_back(1);
      send(3, 8'h70, 1, 0);
      chk("R9 retry same idx1", rd(32'h0C), 32'h0000_C003);
      chk("R9 retry data", rd(BUF_BASE + 16), exp_word(8'h70, 0, 3));
      chk("R7 done after retry", 32'(done_count), 4);
   endtask

   task automatic t_abort;
      give_back(2);
      give_back(3);
      send(20, 8'h80, 1, 1);
      chk("R10 first frag ctrl", rd(32'h14), 32'h0000_4000);
      chk("R10 first frag used", rd(32'h10), tag(2) | 1);
      chk("R10 aborted frag not used", rd(32'h18), tag(3));
      chk("R10 aborted frag ctrl", rd(32'h1C), UNTOUCHED);
      chk("R10 no done", 32'(done_count), 4);
      send(2, 8'h90, 1, 0);
      chk("R10 reuse idx3", rd(32'h1C), 32'h0000_C002);
   endtask

   task automatic t_disabled_stray;
      int w0 = wr_count;
      give_back(0);
      en = 1'b0;
      send(6, 8'hA0, 1, 0);
      chk("R11 disabled no writes", 32'(wr_count - w0), 0);
      chk("R11 disabled no done", 32'(done_count), 5);
      en = 1'b1;
      send(3, 8'hB0, 0, 0);
      chk("R11 stray no writes", 32'(wr_count - w0), 0);
      send(4, 8'hC0, 1, 0);
      chk("R11 frame after stray ctrl", rd(32'h04), 32'h0000_C004);
      chk("R11 frame after stray data", rd(BUF_BASE), exp_word(8'hC0, 0, 4));
      chk("R7 done count", 32'(done_count), 6);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
      for (int i = 0; i < 4; i++) give_back(i);
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      idle(2);
      t_short;
      t_exact;
      t_multi_wrap;
      t_rsrc;
      t_abort;
      t_disabled_stray;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule